// File: doc/BRIEF.md
# Ripple-Carry Bit-Slice ALU

A combinational arithmetic logic unit for a processor datapath. It takes two `WIDTH`-bit operands (32 by default) and a 4-bit operation code. It returns a `WIDTH`-bit result, a flag that is high when the result is all zeros, and a signed-overflow flag. The unit has no clock, no reset and no storage. Its outputs follow its inputs after the logic settles.

The datapath is a chain of identical one-bit slices. The carry runs from bit 0 upward, one slice at a time. Each slice can invert either operand bit. Its operation select then picks one of four values: the AND of the two bits, their OR, the full-adder sum, or a "less" input.

The most significant slice is a distinct variant:
- It derives signed overflow from the carries entering and leaving it.
- It produces a comparison bit equal to its sum XOR that overflow. This bit feeds back into the "less" input of slice 0.
- The "less" input of every other slice is tied low.

Top module: `rca_alu`

## Requirements
- R1: With `ctrl_i` = 4'b0000, `result_o` is the bitwise AND of `a_i` and `b_i`.
- R2: With `ctrl_i` = 4'b0001, `result_o` is the bitwise OR of `a_i` and `b_i`.
- R3: With `ctrl_i` = 4'b1100, `result_o` is the bitwise NOR of `a_i` and `b_i`.
- R4: With `ctrl_i` = 4'b0010, `result_o` is `a_i + b_i` modulo 2^WIDTH (the carry out is discarded).
- R5: With `ctrl_i` = 4'b0110, `result_o` is `a_i - b_i` modulo 2^WIDTH. It is formed by inverting `b_i` and forcing the carry into bit 0 high.
- R6: With `ctrl_i` = 4'b0111, bit 0 of `result_o` is 1 exactly when `a_i` < `b_i` as two's-complement numbers. This holds even when `a_i - b_i` overflows. All other result bits are 0.
- R7: `zero_o` is 1 exactly when every bit of `result_o` is 0, for every operation.
- R8: With `ctrl_i` = 4'b0010, `ovf_o` is 1 exactly when both operands have the same sign and the sum's sign differs from theirs.
- R9: With `ctrl_i` = 4'b0110, `ovf_o` is 1 exactly when the operands have different signs and the difference's sign differs from `a_i`.
- R10: With `ctrl_i` set to AND, OR, NOR or set-less-than, `ovf_o` is 0 whatever the operands are.
- R11: The outputs depend only on the present inputs. A change of inputs between clock edges is reflected before the next edge, with no clock or reset involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| ctrl_i | input | 4 | Operation code: bit 3 inverts a, bit 2 inverts b and sets carry-in, bits 1:0 select the slice output |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when `result_o` is all zeros |
| ovf_o | output | 1 | Signed overflow of ADD or SUB |

## Verification
The assertions are evaluated whenever the inputs change. They assume that `ctrl_i` holds one of the six defined codes. Any other code decodes by its fields into a combination the assertions do not describe.

The stimulus keeps to that assumption by drawing each operation from the list of six codes and never from a random 4-bit value. The operands are random. Directed vectors are added on top of them: the largest positive number plus one, the most negative number minus one, equal operands, and the two signed extremes compared in both orders.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;

  localparam logic [3:0] OP_AND = 4'b0000;
  localparam logic [3:0] OP_OR  = 4'b0001;
  localparam logic [3:0] OP_ADD = 4'b0010;
  localparam logic [3:0] OP_SUB = 4'b0110;
  localparam logic [3:0] OP_SLT = 4'b0111;
  localparam logic [3:0] OP_NOR = 4'b1100;

  typedef struct packed {
    logic       a_inv;
    logic       b_inv;
    slice_sel_e sel;
    logic       cin0;
    logic       ovf_en;
  } slice_ctrl_t;
endpackage

// File: rtl/full_adder.sv
module full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = a_i ^ b_i;
  assign s_o = p ^ c_i;
  assign c_o = (a_i & b_i) | (p & c_i);
endmodule

// File: rtl/alu_ctrl_dec.sv
module alu_ctrl_dec
  import alu_pkg::*;
(
  input  logic [3:0]  ctrl_i,
  output slice_ctrl_t sc_o
);
  always_comb begin
    sc_o.a_inv  = ctrl_i[3];
    sc_o.b_inv  = ctrl_i[2];
    sc_o.sel    = slice_sel_e'(ctrl_i[1:0]);
    // subtraction: the inverted b plus one forms two's complement
    sc_o.cin0   = ctrl_i[2];
    // only plain add/sub report overflow
    sc_o.ovf_en = (ctrl_i[1:0] == SEL_SUM);
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       a_inv_i,
  input  logic       b_inv_i,
  input  slice_sel_e sel_i,
  input  logic       cin_i,
  input  logic       less_i,
  output logic       res_o,
  output logic       cout_o
);
  logic a_x, b_x, sum;

  assign a_x = a_i ^ a_inv_i;
  assign b_x = b_i ^ b_inv_i;

  full_adder i_fa (.a_i(a_x), .b_i(b_x), .c_i(cin_i), .s_o(sum), .c_o(cout_o));

  always_comb begin
    unique case (sel_i)
      SEL_AND: res_o = a_x & b_x;
      SEL_OR:  res_o = a_x | b_x;
      SEL_SUM: res_o = sum;
      default: res_o = less_i;
    endcase
  end
endmodule

// File: rtl/alu_slice_msb.sv
module alu_slice_msb
  import alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       a_inv_i,
  input  logic       b_inv_i,
  input  slice_sel_e sel_i,
  input  logic       cin_i,
  input  logic       less_i,
  output logic       res_o,
  output logic       cout_o,
  output logic       set_o,
  output logic       ovf_o
);
  logic a_x, b_x, sum;

  assign a_x = a_i ^ a_inv_i;
  assign b_x = b_i ^ b_inv_i;

  full_adder i_fa (.a_i(a_x), .b_i(b_x), .c_i(cin_i), .s_o(sum), .c_o(cout_o));

  assign ovf_o = cin_i ^ cout_o;
  // true sign of the difference, corrected when it overflowed
  assign set_o = sum ^ ovf_o;

  always_comb begin
    unique case (sel_i)
      SEL_AND: res_o = a_x & b_x;
      SEL_OR:  res_o = a_x | b_x;
      SEL_SUM: res_o = sum;
      default: res_o = less_i;
    endcase
  end
endmodule

// File: rtl/rca_alu.sv
module rca_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       ctrl_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  slice_ctrl_t      sc;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] less;
  logic             set_w;
  logic             ovf_raw;

  alu_ctrl_dec i_dec (.ctrl_i(ctrl_i), .sc_o(sc));

  assign carry[0] = sc.cin0;
  assign less     = {{(WIDTH-1){1'b0}}, set_w};

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == MSB) begin : g_msb
      alu_slice_msb i_slice (
        .a_i    (a_i[i]),
        .b_i    (b_i[i]),
        .a_inv_i(sc.a_inv),
        .b_inv_i(sc.b_inv),
        .sel_i  (sc.sel),
        .cin_i  (carry[i]),
        .less_i (less[i]),
        .res_o  (result_o[i]),
        .cout_o (carry[i+1]),
        .set_o  (set_w),
        .ovf_o  (ovf_raw)
      );
    end else begin : g_std
      alu_slice i_slice (
        .a_i    (a_i[i]),
        .b_i    (b_i[i]),
        .a_inv_i(sc.a_inv),
        .b_inv_i(sc.b_inv),
        .sel_i  (sc.sel),
        .cin_i  (carry[i]),
        .less_i (less[i]),
        .res_o  (result_o[i]),
        .cout_o (carry[i+1])
      );
    end
  end

  assign zero_o = ~|result_o;
  assign ovf_o  = ovf_raw & sc.ovf_en;
endmodule

// File: rtl/rca_alu_chk.sv
module rca_alu_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       ctrl_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o
);
  logic [WIDTH-1:0] sum_ref, dif_ref;
  logic             lt_ref;

  always_comb begin
    sum_ref = a_i + b_i;
    dif_ref = a_i - b_i;
    lt_ref  = $signed(a_i) < $signed(b_i);
    if (ctrl_i == OP_ADD) begin
      AST_ADD_SUM: assert (result_o == sum_ref) else $error("add result");  // R4
      AST_ADD_OVF: assert (ovf_o == ((a_i[WIDTH-1] == b_i[WIDTH-1]) && (sum_ref[WIDTH-1] != a_i[WIDTH-1])))
        else $error("add overflow");  // R8
    end
    if (ctrl_i == OP_SUB) begin
      AST_SUB_DIF: assert (result_o == dif_ref) else $error("sub result");  // R5
    end
    if (ctrl_i == OP_SLT) begin
      AST_SLT_BIT: assert (result_o == {{(WIDTH-1){1'b0}}, lt_ref}) else $error("slt");  // R6
    end
    if (ctrl_i == OP_AND || ctrl_i == OP_OR || ctrl_i == OP_NOR || ctrl_i == OP_SLT) begin
      AST_NO_OVERFLOW: assert (!ovf_o) else $error("logic overflow");  // R10
    end
    if (ctrl_i == OP_AND) begin
      AST_ZERO_AND: assert (zero_o == ((a_i & b_i) == '0)) else $error("zero flag");  // R7
    end
  end
endmodule

bind rca_alu rca_alu_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_rca_alu.sv
module test_rca_alu;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int WATCHDOG = 50000;

  logic         clk = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [3:0]   ctrl = 4'b0000;
  logic [W-1:0] result;
  logic         zero, ovf;
  int           n_cmp = 0, n_bad = 0;
  bit           done = 0;

  logic [3:0] ops [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};

  always #(CLK_PERIOD/2) clk = ~clk;

  rca_alu #(.WIDTH(W)) i_rca_alu (
    .a_i(a), .b_i(b), .ctrl_i(ctrl),
    .result_o(result), .zero_o(zero), .ovf_o(ovf)
  );

  task automatic cmp(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (a=%h b=%h ctrl=%b)", req, what, act, exp, a, b, ctrl);
    end
  endtask

  function automatic string op_req(logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b1100: return "R3";
      4'b0010: return "R4";
      4'b0110: return "R5";
      default: return "R6";
    endcase
  endfunction

  // behavioural reference, then compare all three outputs
  task automatic check_now();
    logic [W-1:0] er;
    logic         eo;
    string        orq;
    eo  = 1'b0;
    orq = "R10";
    case (ctrl)
      4'b0000: er = a & b;
      4'b0001: er = a | b;
      4'b1100: er = ~(a | b);
      4'b0010: begin
        er = a + b;
        eo = (a[W-1] == b[W-1]) && (er[W-1] != a[W-1]);
        orq = "R8";
      end
      4'b0110: begin
        er = a - b;
        eo = (a[W-1] != b[W-1]) && (er[W-1] != a[W-1]);
        orq = "R9";
      end
      default: er = ($signed(a) < $signed(b)) ? 1 : 0;
    endcase
    cmp(op_req(ctrl), "result", longint'(result), longint'(er));
    cmp("R7", "zero", longint'(zero), longint'(er == '0));
    cmp(orq, "ovf", longint'(ovf), longint'(eo));
  endtask

  task automatic apply(logic [W-1:0] av, logic [W-1:0] bv, logic [3:0] cv);
    @(posedge clk);
    a = av; b = bv; ctrl = cv;
    @(negedge clk);
    check_now();
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // idle state: AND of zeros
    @(negedge clk);
    check_now();

    // R4 R8: positive overflow
    apply(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010);
    // R4 R7: wrap to zero, no signed overflow
    apply(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010);
    // R5 R9: most negative minus one
    apply(32'h8000_0000, 32'h0000_0001, 4'b0110);
    // R5 R7: equal operands
    apply(32'h1234_5678, 32'h1234_5678, 4'b0110);
    // R6: equal operands -> 0
    apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b0111);
    // R6: extremes, subtraction overflows both ways
    apply(32'h8000_0000, 32'h7FFF_FFFF, 4'b0111);
    apply(32'h7FFF_FFFF, 32'h8000_0000, 4'b0111);
    apply(32'hFFFF_FFFF, 32'h0000_0000, 4'b0111);
    // R10: logic ops on overflow-prone operands
    apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'b0000);
    apply(32'h8000_0000, 32'h8000_0000, 4'b0001);
    apply(32'h0000_0000, 32'h0000_0000, 4'b1100);
    apply(32'hFFFF_FFFF, 32'h0000_0000, 4'b1100);

    // R11: change inputs between edges, result settles before next edge
    @(posedge clk);
    a = 32'h0000_00F0; b = 32'h0000_000F; ctrl = 4'b0001;
    #(CLK_PERIOD/4);
    cmp("R11", "mid-cycle", longint'(result), longint'(32'h0000_00FF));
    a = 32'h0000_0005; b = 32'h0000_0003; ctrl = 4'b0010;
    #(CLK_PERIOD/8);
    cmp("R11", "mid-cycle", longint'(result), longint'(32'h0000_0008));

    // random operands, every op
    for (int i = 0; i < 1200; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      rb = (i % 7 == 0) ? ra : W'($urandom);
      if (i % 11 == 0) rb = ra ^ 32'h8000_0000;
      apply(ra, rb, ops[i % 6]);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule